// File: doc/BRIEF.md
# Nested Priority Vectored Interrupt Controller

This block collects a set of interrupt sources and drives a single active-low interrupt request toward a processor core. Each source has a priority from 0 (lowest) to 7 (highest), a choice of level or rising-edge sensitivity, an enable bit and a data word of its own that is handed back as the vector. Software reads an acknowledge register to obtain the vector of the winning source. That read also makes the source's priority the new service level and drops the request line. Software writes an end-of-service register when the handler is done.

A hardware stack of service levels lets a more urgent source interrupt a handler that is already running. While a handler runs, only a source with priority strictly above the current level raises the request. When a handler finishes, its level is popped and the previous level is restored. Sources that were held back are then offered again against that restored level.

The register port is a plain single-cycle bus with no back-pressure. A write takes effect at the clock edge where `bus_sel` and `bus_wr` are both high. A read is presented in the same way with `bus_wr` low, and its data appears on `bus_rdata` from the next clock edge onward. There is no ready signal, because every access completes in one cycle. Register words: 0x00+i sets the configuration of source i (bits 2:0 priority, bit 8 edge mode). 0x20+i sets the vector of source i. 0x40 is the acknowledge read, 0x41 the end-of-service write, 0x42 the enable-set mask and 0x43 the enable-clear mask. 0x44 sets the vector that is returned when nothing qualifies.

Top module: `prio_vic`

## Requirements
- R1: `irq_n` is low exactly when some enabled pending source has a priority above the current level; when the level stack is empty, any enabled pending source counts.
- R2: A read of word 0x40 returns on `bus_rdata`, one cycle later, the vector of the highest-priority enabled pending source; at equal priority the lowest-numbered source wins.
- R3: A qualifying read of 0x40 pushes the winner's priority as the new current level, so `irq_n` goes high unless a source of strictly higher priority is pending.
- R4: A source in edge mode (config bit 8 = 1) latches a rising edge of its input as a sticky pending flag, and that flag is cleared when the acknowledge read selects this source.
- R5: A source in level mode (config bit 8 = 0) is pending while its input is high; the acknowledge read does not clear it, and it does not re-raise `irq_n` at its own level.
- R6: During service, a newly pending source of higher priority pulls `irq_n` low, and a source of equal or lower priority does not.
- R7: A write to 0x41 pops the level stack; afterwards `irq_n` goes low if a pending source lies above the restored level, even if it is at or below the level just finished.
- R8: A read of 0x40 with no qualifying source returns the value written to 0x44 and leaves the level stack unchanged.
- R9: A write to 0x41 while the level stack is empty has no effect.
- R10: Writing a mask to 0x42 sets enable bits and writing a mask to 0x43 clears them; a disabled source never requests, and all sources are disabled after reset.
- R11: The level stack holds 8 entries and is never pushed beyond its depth; nesting several levels deep restores each level in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_in | input | N_SRC | Interrupt source inputs |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 7 | Register word address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid the cycle after a read |
| irq_n | output | 1 | Active-low interrupt request to the core |

## Verification
The bench nests four handlers and then unwinds them. After each end-of-service it checks that the request stays quiet until the restored level falls below a held-back source. A design that compared against the finished level instead of the restored one would miss the final re-request. Two sources of equal priority are raised together to show that the lower index wins. A level source is acknowledged and then observed to stay pending without re-requesting at its own level, while an edge source is shown to be cleared by its acknowledge. The bench also acknowledges with nothing pending and ends service on an empty stack. If either of those touched the stack, a later lone low-priority source would no longer raise the line.

// File: rtl/vic_pkg.sv
package vic_pkg;
  localparam int PRIO_W = 3;
  typedef logic [PRIO_W-1:0] prio_t;

  localparam logic [6:0] A_VEC_BASE = 7'h20;
  localparam logic [6:0] A_ACK      = 7'h40;
  localparam logic [6:0] A_EOI      = 7'h41;
  localparam logic [6:0] A_ENSET    = 7'h42;
  localparam logic [6:0] A_ENCLR    = 7'h43;
  localparam logic [6:0] A_SPUR     = 7'h44;
  localparam int         CFG_EDGE_BIT = 8;
endpackage

// File: rtl/vic_src_bank.sv
module vic_src_bank #(
  parameter int N_SRC = 32,
  localparam int IDX_W = $clog2(N_SRC)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] src_in,
  input  logic [N_SRC-1:0] edge_mode,
  input  logic [N_SRC-1:0] enable,
  input  logic             ack_clr,
  input  logic [IDX_W-1:0] ack_idx,
  output logic [N_SRC-1:0] pend
);
  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    logic smp, prev, lat, rise, clr;
    assign rise = smp && !prev;
    assign clr  = ack_clr && (ack_idx == IDX_W'(i));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        smp  <= 1'b0;
        prev <= 1'b0;
        lat  <= 1'b0;
      end else begin
        smp  <= src_in[i];
        prev <= smp;
        if (!edge_mode[i])  lat <= 1'b0;
        else if (rise)      lat <= 1'b1;
        else if (clr)       lat <= 1'b0;
      end
    end

    assign pend[i] = enable[i] && (edge_mode[i] ? lat : smp);

    AST_EDGE_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !rise) |=> !lat); // R4
  end
endmodule

// File: rtl/vic_arbiter.sv
module vic_arbiter
  import vic_pkg::*;
#(
  parameter int N_SRC = 32,
  localparam int IDX_W = $clog2(N_SRC)
) (
  input  logic [N_SRC-1:0]             pend,
  input  logic [N_SRC-1:0][PRIO_W-1:0] prio,
  output logic                         any,
  output logic [IDX_W-1:0]             win_idx,
  output prio_t                        win_prio
);
  // Scan from the top index down; ">=" lets a lower index take over a tie.
  always_comb begin
    any      = 1'b0;
    win_idx  = '0;
    win_prio = '0;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (pend[i] && (!any || prio[i] >= win_prio)) begin
        any      = 1'b1;
        win_idx  = IDX_W'(i);
        win_prio = prio[i];
      end
    end
  end
endmodule

// File: rtl/vic_level_stack.sv
module vic_level_stack
  import vic_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  push,
  input  logic  pop,
  input  prio_t push_lvl,
  output logic  empty,
  output prio_t top_lvl
);
  prio_t          mem [DEPTH];
  logic  [CW-1:0] depth;
  logic  [AW-1:0] top_idx;

  assign empty   = (depth == '0);
  assign top_idx = AW'(depth - CW'(1));
  assign top_lvl = empty ? '0 : mem[top_idx];

  always_ff @(posedge clk) begin
    if (!rst_n)                              depth <= '0;
    else if (push && depth < CW'(DEPTH))     depth <= depth + CW'(1);
    else if (pop && !empty)                  depth <= depth - CW'(1);
  end

  always_ff @(posedge clk) begin
    if (push && depth < CW'(DEPTH)) mem[AW'(depth)] <= push_lvl;
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (depth < CW'(DEPTH))); // R11
  AST_EMPTY_POP_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push && empty) |=> empty); // R9
endmodule

// File: rtl/prio_vic.sv
module prio_vic
  import vic_pkg::*;
#(
  parameter int N_SRC       = 32,
  parameter int STACK_DEPTH = 8,
  parameter int DATA_W      = 32,
  localparam int IDX_W = $clog2(N_SRC)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_SRC-1:0]  src_in,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [6:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_n
);
  logic [N_SRC-1:0][PRIO_W-1:0] cfg_prio;
  logic [N_SRC-1:0]             cfg_edge;
  logic [N_SRC-1:0]             enable;
  logic [DATA_W-1:0]            vec_mem [N_SRC];
  logic [DATA_W-1:0]            spur_vec;

  logic             wr_en, rd_en, slot_ok, cfg_hit, vec_hit;
  logic [IDX_W-1:0] slot;
  logic             ack, ack_ok, eoi, ack_clr, qualify;
  logic [N_SRC-1:0] pend;
  logic             any;
  logic [IDX_W-1:0] win_idx;
  prio_t            win_prio, stk_top;
  logic             stk_empty;

  assign wr_en   = bus_sel && bus_wr;
  assign rd_en   = bus_sel && !bus_wr;
  assign slot    = bus_addr[IDX_W-1:0];
  assign slot_ok = (int'(bus_addr[4:0]) < N_SRC);
  assign cfg_hit = wr_en && (bus_addr[6:5] == 2'b00) && slot_ok;
  assign vec_hit = wr_en && (bus_addr[6:5] == A_VEC_BASE[6:5]) && slot_ok;
  assign ack     = rd_en && (bus_addr == A_ACK);
  assign eoi     = wr_en && (bus_addr == A_EOI);

  assign qualify = any && (stk_empty || win_prio > stk_top);
  assign ack_ok  = ack && qualify;
  assign ack_clr = ack_ok && cfg_edge[win_idx];
  assign irq_n   = !qualify;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_prio <= '0;
      cfg_edge <= '0;
      enable   <= '0;
      spur_vec <= '0;
    end else if (wr_en) begin
      if (cfg_hit) begin
        cfg_prio[slot] <= bus_wdata[PRIO_W-1:0];
        cfg_edge[slot] <= bus_wdata[CFG_EDGE_BIT];
      end
      if (bus_addr == A_ENSET) enable   <= enable | bus_wdata[N_SRC-1:0];
      if (bus_addr == A_ENCLR) enable   <= enable & ~bus_wdata[N_SRC-1:0];
      if (bus_addr == A_SPUR)  spur_vec <= bus_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (vec_hit) vec_mem[slot] <= bus_wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     bus_rdata <= '0;
    else if (rd_en) bus_rdata <= !ack ? '0 : (qualify ? vec_mem[win_idx] : spur_vec);
  end

  vic_src_bank #(.N_SRC(N_SRC)) u_bank (
    .clk(clk), .rst_n(rst_n), .src_in(src_in), .edge_mode(cfg_edge),
    .enable(enable), .ack_clr(ack_clr), .ack_idx(win_idx), .pend(pend)
  );

  vic_arbiter #(.N_SRC(N_SRC)) u_arb (
    .pend(pend), .prio(cfg_prio), .any(any), .win_idx(win_idx), .win_prio(win_prio)
  );

  vic_level_stack #(.DEPTH(STACK_DEPTH)) u_stk (
    .clk(clk), .rst_n(rst_n), .push(ack_ok), .pop(eoi), .push_lvl(win_prio),
    .empty(stk_empty), .top_lvl(stk_top)
  );

  AST_ACK_SETS_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    ack_ok |=> (!stk_empty && stk_top == $past(win_prio))); // R3
  AST_SPURIOUS_KEEPS_STACK: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !qualify) |=> (stk_empty == $past(stk_empty) && stk_top == $past(stk_top))); // R8
  AST_REQ_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_n |-> (pend != '0)); // R1
endmodule

// File: tb/sim_prio_vic.sv
`timescale 1ns/1ps
module sim_prio_vic;
  localparam int N = 32;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [N-1:0] src = '0;
  logic        sel = 1'b0, wr = 1'b0;
  logic [6:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq_n;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  prio_vic u0 (
    .clk(clk), .rst_n(rst_n), .src_in(src), .bus_sel(sel), .bus_wr(wr),
    .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata), .irq_n(irq_n)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_write(input logic [6:0] a, input logic [31:0] d);
    @(negedge clk); sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
    @(negedge clk); sel = 1'b0; wr = 1'b0;
  endtask

  task automatic bus_read(input logic [6:0] a, output logic [31:0] d);
    @(negedge clk); sel = 1'b1; wr = 1'b0; addr = a;
    @(negedge clk); sel = 1'b0; d = rdata;
  endtask

  task automatic set_src(input int i, input logic v);
    @(negedge clk); src[i] = v;
    idle(3);
  endtask

  task automatic cfg_src(input int i, input int pr, input bit edge_md);
    bus_write(7'(i), (32'(edge_md) << 8) | 32'(pr));
    bus_write(7'h20 + 7'(i), 32'h1000 + 32'(i));
  endtask

  task automatic ack_expect(input string req, input logic [31:0] exp);
    logic [31:0] v;
    bus_read(7'h40, v);
    chk(req, v, exp);
  endtask

  task automatic eoi();
    bus_write(7'h41, 32'h0);
  endtask

  task automatic t_spurious();
    bus_write(7'h44, 32'hDEAD);
    ack_expect("R8 spurious vector", 32'hDEAD);
    chk("R8 no request", 32'(irq_n), 32'd1);
    eoi(); eoi();                               // R9 pops on empty stack
    cfg_src(2, 0, 1'b0);
    bus_write(7'h42, 32'h4);
    set_src(2, 1'b1);
    chk("R9 empty stack keeps lowest priority live", 32'(irq_n), 32'd0);
    ack_expect("R2 prio0 vector", 32'h1002);
    set_src(2, 1'b0);
    eoi();
    chk("R9 idle after cleanup", 32'(irq_n), 32'd1);
  endtask

  task automatic t_level();
    set_src(5, 1'b1);
    chk("R1 level request", 32'(irq_n), 32'd0);
    ack_expect("R2 level vector", 32'h1005);
    chk("R3 ack drops request", 32'(irq_n), 32'd1);
    idle(3);
    chk("R5 no re-request at own level", 32'(irq_n), 32'd1);
    eoi();
    chk("R5 level still pending after pop", 32'(irq_n), 32'd0);
    ack_expect("R5 level vector again", 32'h1005);
    set_src(5, 1'b0);
    eoi();
    chk("R5 released level idle", 32'(irq_n), 32'd1);
  endtask

  task automatic t_edge();
    @(negedge clk); src[9] = 1'b1;
    @(negedge clk); src[9] = 1'b0;
    idle(3);
    chk("R4 sticky edge request", 32'(irq_n), 32'd0);
    ack_expect("R4 edge vector", 32'h1009);
    chk("R4 ack drops request", 32'(irq_n), 32'd1);
    eoi();
    idle(2);
    chk("R4 edge cleared by ack", 32'(irq_n), 32'd1);
  endtask

  task automatic t_tie();
    @(negedge clk); src[3] = 1'b1; src[7] = 1'b1;
    idle(3);
    ack_expect("R2 tie lowest index", 32'h1003);
    eoi();
    set_src(3, 1'b0);
    ack_expect("R2 remaining tied source", 32'h1007);
    set_src(7, 1'b0);
    eoi();
    chk("R2 idle after ties", 32'(irq_n), 32'd1);
  endtask

  task automatic t_nest();
    set_src(10, 1'b1);
    ack_expect("R11 level1 vector", 32'h100A);
    set_src(12, 1'b1);
    chk("R6 higher preempts", 32'(irq_n), 32'd0);
    ack_expect("R11 level3 vector", 32'h100C);
    set_src(14, 1'b1);
    chk("R6 equal priority held back", 32'(irq_n), 32'd1);
    @(negedge clk); src[11] = 1'b1;
    @(negedge clk); src[11] = 1'b0;
    idle(3);
    chk("R6 edge prio5 preempts", 32'(irq_n), 32'd0);
    ack_expect("R11 level5 vector", 32'h100B);
    set_src(13, 1'b1);
    ack_expect("R11 level6 vector", 32'h100D);
    set_src(13, 1'b0);
    eoi();
    chk("R7 restored level5 quiet", 32'(irq_n), 32'd1);
    eoi();
    chk("R7 restored level3 quiet", 32'(irq_n), 32'd1);
    eoi();
    chk("R7 restored level1 re-requests", 32'(irq_n), 32'd0);
    ack_expect("R7 held-back tie vector", 32'h100C);
    @(negedge clk); src[10] = 1'b0; src[12] = 1'b0; src[14] = 1'b0;
    idle(3);
    eoi(); eoi();
    chk("R11 fully unwound", 32'(irq_n), 32'd1);
  endtask

  task automatic t_enable();
    set_src(20, 1'b1);
    chk("R10 disabled source silent", 32'(irq_n), 32'd1);
    bus_write(7'h42, 32'h0010_0000);
    chk("R10 enable-set requests", 32'(irq_n), 32'd0);
    ack_expect("R10 enabled vector", 32'h1014);
    bus_write(7'h43, 32'h0010_0000);
    eoi();
    chk("R10 disable-clear silences", 32'(irq_n), 32'd1);
    ack_expect("R10 disabled gives spurious", 32'hDEAD);
    set_src(20, 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    idle(3);
    @(negedge clk); rst_n = 1'b1;
    chk("R1 reset no request", 32'(irq_n), 32'd1);
    chk("R2 reset read data", rdata, 32'h0);
    cfg_src(5, 3, 1'b0);
    cfg_src(9, 2, 1'b1);
    cfg_src(3, 4, 1'b0);
    cfg_src(7, 4, 1'b0);
    cfg_src(10, 1, 1'b0);
    cfg_src(11, 5, 1'b1);
    cfg_src(12, 3, 1'b0);
    cfg_src(13, 6, 1'b0);
    cfg_src(14, 3, 1'b0);
    cfg_src(20, 2, 1'b0);
    bus_write(7'h42, 32'h0000_7EA8);
    t_spurious();
    t_level();
    t_edge();
    t_tie();
    t_nest();
    t_enable();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule